// File: doc/BRIEF.md
# Dithering Phase-Shift Modulator

This block drives the two half-bridges of a dual-active half-bridge converter with a pair of square waves at a fixed switching frequency. A free-running period counter of 2^CNT_W clock cycles sets the period. The reference wave is high in the first half of each period. The second wave is the same waveform, delayed by a phase shift that is given as a 12-bit command.

The counter alone resolves only the upper eight command bits: one counter step is 1/256 of a period. The four lower bits are reached by dithering. In every period the block uses either the coarse shift or the coarse shift plus one step. A small accumulator spreads the coarse-plus-one periods evenly, so that over a 16-period frame the mean shift equals the full command. The command is taken only at a period boundary, so every period holds a single shift from start to end. A one-cycle strobe marks each period start. Dropping the enable silences the outputs and restarts the counter and the dither pattern from zero.

Top module: `dpsm_top`

## Requirements
- R1: While reset is asserted, and on every clock after one where en_i was sampled low, ref_o, shf_o and prd_o are all 0.
- R2: Once enabled, the period is 256 clocks. prd_o is high for exactly one clock, the clock that holds count 0, and its first pulse follows the first clock edge at which en_i is sampled high.
- R3: ref_o is 1 for counts 0 to 127 of each period and 0 for counts 128 to 255.
- R4: shf_o at count c is 1 exactly when (c - s) mod 256 < 128. Here s is the shift that applies to the current period.
- R5: s equals coarse or (coarse + 1) mod 256, where coarse = phase_i[11:4].
- R6: A 4-bit accumulator starts at 0 on enable. At each period start it adds frac = phase_i[3:0], and a carry out of bit 3 selects coarse + 1 for that period. With a constant command, each 16-period frame from enable therefore holds exactly frac coarse+1 periods.
- R7: phase_i is sampled only at the clock that holds count 0. Changes at other times have no effect on the current period.
- R8: When coarse = 255 and the dither selects coarse + 1, s wraps to 0. Within counts 1 to 255 of any period, shf_o changes at most twice.
- R9: Lowering en_i clears the counter and the accumulator. After re-enable, the count and the dither pattern restart exactly as they did after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears and silences the block |
| phase_i | input | 12 | Phase command: coarse steps in [11:4], fraction in [3:0] |
| ref_o | output | 1 | Reference square wave |
| shf_o | output | 1 | Phase-shifted square wave |
| prd_o | output | 1 | One-clock strobe at each period start |

## Verification
The sampling of a new command and the dither carry both fall on the period-start clock. At that clock a command change can also meet a coarse value of 255, where the carry wraps the shift to zero. The bench changes the command in mid-period and at boundaries, and runs a full-scale command whose carry periods wrap. It checks every output on every clock against its own accumulator model. It also reads each period's shift back from the position of the rising edge of shf_o, and counts how many coarse+1 periods fall in each frame.

// File: rtl/dpsm_pkg.sv
package dpsm_pkg;
    localparam int unsigned DPSM_CNT_W  = 8;
    localparam int unsigned DPSM_FRAC_W = 4;

    typedef enum logic {
        SEL_COARSE = 1'b0,
        SEL_FINE   = 1'b1
    } dith_sel_e;
endpackage

// File: rtl/dpsm_timebase.sv
module dpsm_timebase #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             start_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        cnt_o   = st_q.cnt;
        start_o = en_i && (st_q.cnt == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dpsm_dither.sv
module dpsm_dither
    import dpsm_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned FRAC_W = 4,
    localparam int unsigned CMD_W = CNT_W + FRAC_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             start_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic [CNT_W-1:0] shift_o
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
        logic [CNT_W-1:0]  shift;
    } dith_state_t;

    dith_state_t st_d, st_q;

    logic [FRAC_W:0]    sum;
    dith_sel_e          sel;
    logic [CNT_W-1:0]   coarse;
    logic [CNT_W-1:0]   cand;

    always_comb begin
        coarse = cmd_i[CMD_W-1:FRAC_W];
        sum    = {1'b0, st_q.acc} + {1'b0, cmd_i[FRAC_W-1:0]};
        sel    = sum[FRAC_W] ? SEL_FINE : SEL_COARSE;
        cand   = (sel == SEL_FINE) ? coarse + 1'b1 : coarse;

        st_d    = st_q;
        shift_o = st_q.shift;
        if (!en_i) begin
            st_d = '0;
        end else if (start_i) begin
            st_d.acc   = sum[FRAC_W-1:0];
            st_d.shift = cand;
            shift_o    = cand;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dpsm_wave.sv
module dpsm_wave #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] shift_i,
    output logic             ref_o,
    output logic             shf_o,
    output logic             prd_o
);
    typedef struct packed {
        logic ref_w;
        logic shf_w;
        logic prd;
    } wave_state_t;

    wave_state_t      st_d, st_q;
    logic [CNT_W-1:0] lag;

    always_comb begin
        lag        = cnt_i - shift_i;
        st_d.ref_w = en_i && !cnt_i[CNT_W-1];
        st_d.shf_w = en_i && !lag[CNT_W-1];
        st_d.prd   = start_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_o = st_q.ref_w;
    assign shf_o = st_q.shf_w;
    assign prd_o = st_q.prd;
endmodule

// File: rtl/dpsm_top.sv
module dpsm_top #(
    parameter int unsigned CNT_W  = dpsm_pkg::DPSM_CNT_W,
    parameter int unsigned FRAC_W = dpsm_pkg::DPSM_FRAC_W,
    localparam int unsigned CMD_W = CNT_W + FRAC_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CMD_W-1:0] phase_i,
    output logic             ref_o,
    output logic             shf_o,
    output logic             prd_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] shift;
    logic             start;

    dpsm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .cnt_o   (cnt),
        .start_o (start)
    );

    dpsm_dither #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_dith (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .start_i (start),
        .cmd_i   (phase_i),
        .shift_o (shift)
    );

    dpsm_wave #(.CNT_W(CNT_W)) u_wave (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .start_i (start),
        .cnt_i   (cnt),
        .shift_i (shift),
        .ref_o   (ref_o),
        .shf_o   (shf_o),
        .prd_o   (prd_o)
    );
endmodule

// File: rtl/dpsm_chk.sv
module dpsm_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic ref_o,
    input logic shf_o,
    input logic prd_o
);
    localparam int unsigned PERIOD = 1 << CNT_W;
    localparam int unsigned HALF   = PERIOD / 2;

    logic [CNT_W:0] gap_q;
    logic           seen_q;
    logic           en_prev_q;
    logic           shf_prev_q;
    logic [2:0]     edge_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q      <= '0;
            seen_q     <= 1'b0;
            en_prev_q  <= 1'b0;
            shf_prev_q <= 1'b0;
            edge_q     <= '0;
        end else begin
            en_prev_q  <= en_i;
            shf_prev_q <= shf_o;
            if (!en_i) begin
                gap_q  <= '0;
                seen_q <= 1'b0;
                edge_q <= '0;
            end else if (prd_o) begin
                gap_q  <= 1;
                seen_q <= 1'b1;
                edge_q <= '0;
            end else begin
                gap_q <= gap_q + 1'b1;
                if (shf_o != shf_prev_q && edge_q != 3'd7) begin
                    edge_q <= edge_q + 1'b1;
                end
            end
        end
    end

    // R1: silent outputs after a disabled clock
    a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_prev_q |-> (!ref_o && !shf_o && !prd_o));

    // R2: strobe spacing equals one full period
    a_r2_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prd_o && seen_q) |-> (gap_q == (CNT_W+1)'(PERIOD)));

    // R2: strobe lasts one clock
    a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prd_o |=> !prd_o);

    // R3: reference falls at mid-period
    a_r3_ref_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(ref_o) && seen_q && en_prev_q) |-> (gap_q == (CNT_W+1)'(HALF)));

    // R3: reference high at period start
    a_r3_ref_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prd_o |-> ref_o);

    // R8: no more than two shifted-wave edges inside a period
    a_r8_edge_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_q <= 3'd2);
endmodule

bind dpsm_top dpsm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .ref_o  (ref_o),
    .shf_o  (shf_o),
    .prd_o  (prd_o)
);

// File: tb/sim_dpsm_top.sv
`timescale 1ns/1ps
module sim_dpsm_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_i = 1'b0;
    logic [11:0] phase_i = '0;
    logic        ref_o, shf_o, prd_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int         n = 0;
    logic [3:0] bacc = '0;
    logic [7:0] bcoarse = '0;
    logic [7:0] bshift = '0;
    int         rise = 0;
    int         carries = 0;
    logic       prev_shf = 1'b0;

    always #4 clk_i = ~clk_i;

    dpsm_top u0 (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .phase_i (phase_i),
        .ref_o   (ref_o),
        .shf_o   (shf_o),
        .prd_o   (prd_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic shf_model(input int c, input logic [7:0] s);
        return (((c - int'(s)) & 255) < 128);
    endfunction

    task automatic step(input logic en, input logic [11:0] cmd, input string tag);
        int   c;
        logic e_ref, e_shf, e_stb;
        logic [4:0] sum;
        @(negedge clk_i);
        en_i    = en;
        phase_i = cmd;
        if (en) begin
            c = n % 256;
            if (c == 0) begin
                sum     = {1'b0, bacc} + {1'b0, cmd[3:0]};
                bacc    = sum[3:0];
                bcoarse = cmd[11:4];
                bshift  = bcoarse + {7'd0, sum[4]};
            end
            e_ref = (c < 128);
            e_stb = (c == 0);
            e_shf = shf_model(c, bshift);
            n++;
        end else begin
            c = -1;
            n = 0;
            bacc = '0;
            e_ref = 0; e_stb = 0; e_shf = 0;
        end
        @(posedge clk_i);
        #2;
        if (en) begin
            chk("R3", ref_o, e_ref);
            chk("R2", prd_o, e_stb);
            chk(tag, shf_o, e_shf);
        end else begin
            chk("R1", ref_o, 0);
            chk("R1", prd_o, 0);
            chk("R1", shf_o, 0);
        end
        if (c == 0) rise = 0;
        if (c >= 1 && shf_o && !prev_shf) rise = c;
        if (c == 255) begin
            chk("R5", rise, int'(bshift));
            if (((rise - int'(bcoarse)) & 255) == 1) carries++;
        end
        prev_shf = shf_o;
    endtask

    task automatic frame(input logic [11:0] cmd, input string tag);
        carries = 0;
        for (int i = 0; i < 16 * 256; i++) step(1'b1, cmd, tag);
        chk("R6", carries, int'(cmd[3:0]));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] a, b;
        void'($urandom(32'h1a2b3c));
        repeat (4) @(posedge clk_i);
        #2;
        chk("R1", ref_o, 0);
        chk("R1", shf_o, 0);
        chk("R1", prd_o, 0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        for (int i = 0; i < 6; i++) step(1'b0, 12'h3C7, "R1");

        frame(12'h000, "R4");
        frame(12'h008, "R4");
        frame(12'hFFF, "R8");
        frame(12'h801, "R4");
        frame(12'hFF7, "R8");
        for (int k = 0; k < 3; k++) frame(12'($urandom), "R4");

        // R7: mid-period command change is ignored until the next boundary
        a = 12'h2A9;
        b = 12'hD13;
        for (int i = 0; i < 100; i++) step(1'b1, a, "R7");
        for (int i = 100; i < 256; i++) step(1'b1, b, "R7");
        for (int i = 0; i < 256; i++) step(1'b1, b, "R7");
        for (int i = 0; i < 77; i++) step(1'b1, 12'($urandom), "R7");

        // R9: disable mid-period, then restart the pattern from zero
        for (int i = 0; i < 40; i++) step(1'b0, 12'($urandom), "R1");
        frame(12'h0A5, "R9");
        for (int i = 0; i < 300; i++) step(1'b1, 12'h44B, "R9");
        step(1'b0, 12'h44B, "R1");
        frame(12'h7FD, "R9");
        frame(12'($urandom), "R4");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule